// File: doc/BRIEF.md
# Configuration Readback Permission Controller

This block sits between a reconfigurable device's configuration store and its serial readback port, and decides whether a readback request is honoured. Every configuration load delivers a 2-bit policy code that is held until the next load. The code allows readback without limit, allows it a single time, or forbids it entirely. Until the first load, nothing is configured and every request is refused.

A granted readback sends the stored configuration words one bit per clock, most significant bit first. The block steps an address through the external store to fetch each word. After the words it sends a snapshot of the logic-cell output states, taken in the cycle the request was accepted. Then it pulses a completion strobe. A refused request produces only a one-cycle refusal strobe. A status output shows at all times whether a request would be refused.

Top module: `rbk_guard`

## Requirements
- R1: A pulse on `cfg_load` latches `cfg_mode` and marks the device configured. After reset, and before the first load, every request is refused and `rb_locked` is 1. When `cfg_load` and `rb_req` are high in the same cycle, the request is ignored: no grant and no deny.
- R2: Mode code 2'b00 (unlimited) grants every request made while no transfer is running, any number of times.
- R3: Mode code 2'b01 (single use) grants the first request after a load. Once that transfer has completed, every request is refused until the next `cfg_load`, which allows readback again.
- R4: Mode codes 2'b10 and 2'b11 refuse every request.
- R5: A refused request raises `rb_deny` for exactly the next cycle. `rb_grant` stays low and nothing is shifted out.
- R6: For a granted request, `rb_grant` rises in the next cycle and stays high for exactly CFG_WORDS*WORD_W + CELL_W consecutive cycles. During that time `rb_dout` carries one bit per cycle: words at addresses 0 up to CFG_WORDS-1, each MSB first (with `mem_addr` giving the word being sent), then the cell snapshot, MSB first.
- R7: The cell snapshot is the value of `cell_state` in the cycle the request was accepted. Later changes do not affect it.
- R8: `rb_done` pulses for one cycle in the cycle after the last bit, with `rb_grant` already low.
- R9: A request made while `rb_grant` is high is ignored. It does not restart the stream, does not lengthen it, and raises no deny.
- R10: `cfg_load` during a transfer aborts it. `rb_grant` is low in the next cycle and no `rb_done` follows.
- R11: `rb_locked` is 1 exactly when a request made now would be refused. This is the case when the device is unconfigured, the mode is never, or the mode is single use and the single transfer has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe: a configuration load has completed |
| cfg_mode | input | 2 | Readback policy code captured on `cfg_load` |
| rb_req | input | 1 | Readback request |
| cell_state | input | CELL_W | Current logic-cell output states |
| mem_data | input | WORD_W | Configuration word at `mem_addr` (combinational read) |
| rb_grant | output | 1 | High while a granted stream is being sent |
| rb_deny | output | 1 | One-cycle refusal strobe |
| rb_dout | output | 1 | Serial readback data |
| rb_done | output | 1 | One-cycle end-of-stream strobe |
| rb_locked | output | 1 | A request now would be refused |
| mem_addr | output | AW | Index of the configuration word being sent |

## Verification
The assertions assume that `rb_req` and `cfg_load` are synchronous to `clk`. They also assume that `mem_data` settles within the cycle `mem_addr` presents. The bench changes every input half a period away from the active edge and models the store as combinational logic driven by `mem_addr`. No assumption is made about request spacing: requests during a stream, in the completion cycle and together with a load are all legal, and the bench drives each of these cases on purpose.

// File: rtl/rbk_pkg.sv
`timescale 1ns/1ps
package rbk_pkg;
   typedef enum logic [1:0] {
      RB_FREE  = 2'b00,
      RB_ONCE  = 2'b01,
      RB_NONE  = 2'b10,
      RB_NONE2 = 2'b11
   } rb_mode_t;

   function automatic logic mode_allows(input rb_mode_t m, input logic used);
      case (m)
         RB_FREE: return 1'b1;
         RB_ONCE: return !used;
         default: return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/rbk_policy.sv
`timescale 1ns/1ps
module rbk_policy
   import rbk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_load,
   input  logic [1:0] cfg_mode,
   input  logic       xfer_end,
   output logic       allow
);
   rb_mode_t mode_q;
   logic     cfgd_q;
   logic     used_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= RB_NONE;
         cfgd_q <= 1'b0;
         used_q <= 1'b0;
      end else if (cfg_load) begin
         mode_q <= rb_mode_t'(cfg_mode);
         cfgd_q <= 1'b1;
         used_q <= 1'b0;
      end else if (xfer_end) begin
         used_q <= 1'b1;
      end
   end

   assign allow = cfgd_q && mode_allows(mode_q, used_q);

   // R3
   once_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_load && cfg_mode == 2'b01) |=> allow);
   // R4
   never_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_load && cfg_mode[1]) |=> !allow);
endmodule

// File: rtl/rbk_stream.sv
`timescale 1ns/1ps
module rbk_stream #(
   parameter int WORD_W    = 8,
   parameter int CFG_WORDS = 4,
   parameter int CELL_W    = 6,
   localparam int AW = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1,
   localparam int WB = $clog2(WORD_W),
   localparam int CB = $clog2(CELL_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic [CELL_W-1:0] cell_state,
   input  logic [WORD_W-1:0] mem_data,
   output logic              busy,
   output logic              dout,
   output logic [AW-1:0]     addr,
   output logic              last_bit,
   output logic              done
);
   logic              busy_q, in_cell_q, done_q;
   logic [AW-1:0]     word_q;
   logic [WB-1:0]     wbit_q;
   logic [CB-1:0]     cbit_q;
   logic [CELL_W-1:0] snap_q;

   assign last_bit = busy_q && in_cell_q && (cbit_q == '0) && !abort;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         in_cell_q <= 1'b0;
         done_q    <= 1'b0;
         word_q    <= '0;
         wbit_q    <= '0;
         cbit_q    <= '0;
         snap_q    <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            busy_q    <= 1'b1;
            in_cell_q <= 1'b0;
            word_q    <= '0;
            wbit_q    <= WB'(WORD_W - 1);
            cbit_q    <= CB'(CELL_W - 1);
            snap_q    <= cell_state;
         end else if (busy_q) begin
            if (!in_cell_q) begin
               if (wbit_q == '0) begin
                  wbit_q <= WB'(WORD_W - 1);
                  if (word_q == AW'(CFG_WORDS - 1)) in_cell_q <= 1'b1;
                  else word_q <= word_q + 1'b1;
               end else begin
                  wbit_q <= wbit_q - 1'b1;
               end
            end else if (cbit_q == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cbit_q <= cbit_q - 1'b1;
               snap_q <= {snap_q[CELL_W-2:0], 1'b0};
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign addr = word_q;
   assign dout = busy_q ? (in_cell_q ? snap_q[CELL_W-1] : mem_data[wbit_q]) : 1'b0;

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
endmodule

// File: rtl/rbk_guard.sv
`timescale 1ns/1ps
module rbk_guard #(
   parameter int WORD_W    = 8,
   parameter int CFG_WORDS = 4,
   parameter int CELL_W    = 6,
   localparam int AW = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [1:0]        cfg_mode,
   input  logic              rb_req,
   input  logic [CELL_W-1:0] cell_state,
   input  logic [WORD_W-1:0] mem_data,
   output logic              rb_grant,
   output logic              rb_deny,
   output logic              rb_dout,
   output logic              rb_done,
   output logic              rb_locked,
   output logic [AW-1:0]     mem_addr
);
   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("rbk_guard: WORD_W must be at least 2");
      end
      if (CELL_W < 2) begin : g_bad_cell
         $error("rbk_guard: CELL_W must be at least 2");
      end
      if (CFG_WORDS < 2) begin : g_bad_depth
         $error("rbk_guard: CFG_WORDS must be at least 2");
      end
   endgenerate

   logic allow, busy, last_bit, take, deny_q;

   rbk_policy u_policy (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_load (cfg_load),
      .cfg_mode (cfg_mode),
      .xfer_end (last_bit),
      .allow    (allow)
   );

   assign take = rb_req && !busy && !cfg_load;

   rbk_stream #(
      .WORD_W    (WORD_W),
      .CFG_WORDS (CFG_WORDS),
      .CELL_W    (CELL_W)
   ) u_stream (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (take && allow),
      .abort      (cfg_load),
      .cell_state (cell_state),
      .mem_data   (mem_data),
      .busy       (busy),
      .dout       (rb_dout),
      .addr       (mem_addr),
      .last_bit   (last_bit),
      .done       (rb_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) deny_q <= 1'b0;
      else        deny_q <= take && !allow;
   end

   assign rb_deny   = deny_q;
   assign rb_grant  = busy;
   assign rb_locked = !allow;

   // R5
   deny_grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rb_deny && rb_grant));
   // R5
   deny_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rb_deny |-> $past(rb_req));
   // R6
   grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rb_grant) |-> $past(rb_req));
   // R8
   done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rb_done |-> !rb_grant);
   // R9
   busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_grant && rb_req && !cfg_load) |=> !rb_deny);
   // R10
   load_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (!rb_grant && !rb_done && !rb_deny));
   // R11
   locked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_locked && rb_req && !rb_grant && !cfg_load) |=> rb_deny);
endmodule

// File: tb/rbk_guard_test.sv
`timescale 1ns/1ps
module rbk_guard_test;
   localparam int WORD_W = 8;
   localparam int CFG_WORDS = 4;
   localparam int CELL_W = 6;
   localparam int AW = 2;
   localparam int TOTAL = CFG_WORDS * WORD_W + CELL_W;

   // {mode, expected grant for request 1,2,3}
   localparam logic [4:0] VEC [4] = '{
      {2'b00, 3'b111}, {2'b01, 3'b100}, {2'b10, 3'b000}, {2'b11, 3'b000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_load = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic rb_req = 1'b0;
   logic [CELL_W-1:0] cell_state = '0;
   logic [WORD_W-1:0] mem_data;
   logic rb_grant, rb_deny, rb_dout, rb_done, rb_locked;
   logic [AW-1:0] mem_addr;
   logic [7:0] seed = 8'h5C;
   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   always_comb mem_data = seed ^ (8'(mem_addr) * 8'h3B);

   rbk_guard #(.WORD_W(WORD_W), .CFG_WORDS(CFG_WORDS), .CELL_W(CELL_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
      .rb_req(rb_req), .cell_state(cell_state), .mem_data(mem_data),
      .rb_grant(rb_grant), .rb_deny(rb_deny), .rb_dout(rb_dout),
      .rb_done(rb_done), .rb_locked(rb_locked), .mem_addr(mem_addr)
   );

   function automatic logic [7:0] pat(input int a);
      return seed ^ (8'(a) * 8'h3B);
   endfunction

   function automatic logic [63:0] exp_stream(input logic [CELL_W-1:0] cs);
      logic [63:0] e = '0;
      for (int w = 0; w < CFG_WORDS; w++)
         for (int b = WORD_W - 1; b >= 0; b--) e = {e[62:0], pat(w)[b]};
      for (int b = CELL_W - 1; b >= 0; b--) e = {e[62:0], cs[b]};
      return e;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] m);
      @(negedge clk); cfg_load = 1'b1; cfg_mode = m;
      @(negedge clk); cfg_load = 1'b0;
   endtask

   task automatic do_req(input bit exp_g, input logic [CELL_W-1:0] cs,
                         input bit mid, input string rq);
      logic [63:0] got = '0;
      bit bad = 1'b0;
      @(negedge clk); rb_req = 1'b1; cell_state = cs;
      @(negedge clk); rb_req = 1'b0; cell_state = ~cs;
      if (exp_g) begin
         chk(rb_grant && !rb_deny, {rq, " grant"}, {62'd0, rb_grant, rb_deny}, 64'h2);
         for (int i = 0; i < TOTAL; i++) begin
            if (!rb_grant || rb_deny) bad = 1'b1;
            got = {got[62:0], rb_dout};
            if (mid && i == 5) rb_req = 1'b1;
            if (mid && i == 6) rb_req = 1'b0;
            @(negedge clk);
         end
         chk(!bad && got == exp_stream(cs), {rq, " R6 R7 stream"}, got, exp_stream(cs));
         chk(!rb_grant && rb_done, {rq, " R8 done"}, {62'd0, rb_grant, rb_done}, 64'h1);
         @(negedge clk);
         chk(!rb_done && !rb_deny, {rq, " R8 pulse"}, {62'd0, rb_done, rb_deny}, 64'h0);
      end else begin
         chk(rb_deny && !rb_grant, {rq, " R5 deny"}, {62'd0, rb_grant, rb_deny}, 64'h1);
         @(negedge clk);
         chk(!rb_deny && !rb_grant && !rb_done, {rq, " R5 one cycle"},
             {61'd0, rb_deny, rb_grant, rb_done}, 64'h0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!rb_grant && !rb_deny && !rb_done && rb_locked, "R1 reset",
          {60'd0, rb_grant, rb_deny, rb_done, rb_locked}, 64'h1);
      do_req(1'b0, 6'h15, 1'b0, "R1 unconfigured");

      // table of modes: R2 R3 R4 R11
      for (int v = 0; v < 4; v++) begin
         cfg(VEC[v][4:3]);
         chk(rb_locked == !VEC[v][2], "R11 after load", {63'd0, rb_locked}, {63'd0, !VEC[v][2]});
         for (int k = 0; k < 3; k++)
            do_req(VEC[v][2-k], 6'(6'h2B + v * 7 + k), 1'b0, "R2 R3 R4 table");
         chk(rb_locked == !VEC[v][0], "R11 end", {63'd0, rb_locked}, {63'd0, !VEC[v][0]});
      end

      // R3 reload re-enables single use
      cfg(2'b01);
      do_req(1'b1, 6'h3C, 1'b0, "R3 first");
      do_req(1'b0, 6'h03, 1'b0, "R3 second");
      seed = 8'hA7;
      cfg(2'b01);
      do_req(1'b1, 6'h21, 1'b0, "R3 after reload");
      do_req(1'b0, 6'h12, 1'b0, "R3 used again");

      // R9 request during stream ignored
      cfg(2'b00);
      do_req(1'b1, 6'h2D, 1'b1, "R9 mid request");

      // R10 abort by load
      @(negedge clk); rb_req = 1'b1; cell_state = 6'h0F;
      @(negedge clk); rb_req = 1'b0;
      repeat (10) @(negedge clk);
      cfg_load = 1'b1; cfg_mode = 2'b10;
      @(negedge clk); cfg_load = 1'b0;
      chk(!rb_grant, "R10 abort", {63'd0, rb_grant}, 64'h0);
      begin
         bit seen = 1'b0;
         for (int i = 0; i < 40; i++) begin
            if (rb_done || rb_grant) seen = 1'b1;
            @(negedge clk);
         end
         chk(!seen, "R10 no done", {63'd0, seen}, 64'h0);
      end
      do_req(1'b0, 6'h01, 1'b0, "R4 after abort");

      // R1 load and request in the same cycle
      @(negedge clk); cfg_load = 1'b1; cfg_mode = 2'b00; rb_req = 1'b1;
      @(negedge clk); cfg_load = 1'b0; rb_req = 1'b0;
      chk(!rb_grant && !rb_deny && !rb_locked, "R1 same cycle",
          {61'd0, rb_grant, rb_deny, rb_locked}, 64'h0);
      do_req(1'b1, 6'h2A, 1'b0, "R2 after same cycle");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule